// File: doc/BRIEF.md
# Dithered PWM Generator

The block drives one PWM output whose duty can be set more finely than one counter step. A prescaler divides the clock by an integer, and a period counter counts a programmable number of prescaled ticks. The requested duty is written in tenths of a counter step. On each PWM period the compare value is one of the two coarse levels that lie on either side of the request. Over a frame of ten consecutive periods, the number of periods at the upper level equals the fractional part of the request. The mean duty over the frame therefore matches the fine request. Any single period is still quantised to whole counter steps, so the finer resolution only shows after low-pass filtering.

The upper-level periods are spread evenly through the frame by an error-diffusion accumulator, which keeps low-frequency ripple small. Prescaler, period and duty pass through shadow registers. They are committed only at a frame boundary, so one frame never mixes two settings. A one-cycle strobe marks every period start, and a second strobe marks the first period of every frame.

Top module: `dpwm_top`

## Requirements
- R1: With prescale value P and period value N (N >= 1), every PWM period lasts exactly N*(P+1) clock cycles, and `period_stb_o` is high for one cycle at the start of each period.
- R2: A frame is ten periods long. `frame_stb_o` is high for one cycle, only in a cycle where `period_stb_o` is also high, at the start of the first period of each frame.
- R3: The duty word D is read as D = 10*C + F with 0 <= F <= 9. Whenever C+1 <= N, the number of cycles `pwm_o` is high across one frame is (P+1)*D.
- R4: In slot k of a frame (k = 0..9), the compare level is C+1 if floor((k+1)*F/10) > floor(k*F/10), and C otherwise. The period in that slot is high for (P+1)*min(level, N) cycles, starting at the period start, and low for the rest.
- R5: A compare level of zero keeps `pwm_o` low for the entire period.
- R6: A compare level at or above N keeps `pwm_o` high for the entire period, with no low cycle.
- R7: A change to the prescale, period or duty inputs during a frame has no effect on that frame. It applies from the next frame boundary onward.
- R8: While `rst` is high, `pwm_o`, `period_stb_o` and `frame_stb_o` are all low. After release, a frame begins with both strobes raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prescale_i | input | PRE_W (8) | Prescale value P; each counter step lasts P+1 cycles |
| period_i | input | PER_W (8) | Counter steps per PWM period N |
| duty_i | input | PER_W+4 (12) | Fine duty in tenths of a counter step |
| pwm_o | output | 1 | Registered PWM output |
| period_stb_o | output | 1 | One-cycle pulse at each period start |
| frame_stb_o | output | 1 | One-cycle pulse at each frame start |

## Verification
The hardest condition to reach from the ports is an input change that lands in the middle of a frame, combined with proof that the running frame keeps its old settings. The bench waits for a frame strobe, lets twenty cycles pass, and then switches all three inputs at once. It then measures the frame that finishes next and expects the old length and high count. The slot-by-slot placement of upper-level periods is observed indirectly. For each vector, the bench counts high cycles between successive period strobes and compares them with the floor-difference rule for every slot of a settled frame.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  localparam int DEF_FRAME_LEN = 10;

  typedef enum logic {
    PH_LOAD = 1'b0,
    PH_RUN  = 1'b1
  } phase_t;
endpackage

// File: rtl/dpwm_shadow.sv
module dpwm_shadow #(
  parameter int PRE_W     = 8,
  parameter int PER_W     = 8,
  parameter int DUTY_W    = 12,
  parameter int FRAME_LEN = 10,
  localparam int REM_W    = $clog2(FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [PRE_W-1:0]  pre_i,
  input  logic [PER_W-1:0]  per_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic [PRE_W-1:0]  act_pre,
  output logic [PER_W-1:0]  act_per,
  output logic [DUTY_W-1:0] act_coarse,
  output logic [REM_W-1:0]  act_rem,
  output logic [DUTY_W-1:0] nx_coarse,
  output logic [REM_W-1:0]  nx_rem
);
  logic [PRE_W-1:0]  sh_pre;
  logic [PER_W-1:0]  sh_per;
  logic [DUTY_W-1:0] sh_duty;
  logic [DUTY_W-1:0] sh_coarse;
  logic [REM_W-1:0]  sh_rem;

  // Staging copy of the inputs, refreshed every cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_pre  <= '0;
      sh_per  <= '0;
      sh_duty <= '0;
    end else begin
      sh_pre  <= pre_i;
      sh_per  <= per_i;
      sh_duty <= duty_i;
    end
  end

  // Integer and fractional part of the fine duty
  assign sh_coarse = sh_duty / DUTY_W'(FRAME_LEN);
  assign sh_rem    = REM_W'(sh_duty % DUTY_W'(FRAME_LEN));

  // Active settings change only on a frame load
  always_ff @(posedge clk) begin
    if (rst) begin
      act_pre    <= '0;
      act_per    <= '0;
      act_coarse <= '0;
      act_rem    <= '0;
    end else if (load) begin
      act_pre    <= sh_pre;
      act_per    <= sh_per;
      act_coarse <= sh_coarse;
      act_rem    <= sh_rem;
    end
  end

  // Values the dither stage must use on the edge of a load
  assign nx_coarse = load ? sh_coarse : act_coarse;
  assign nx_rem    = load ? sh_rem    : act_rem;
endmodule

// File: rtl/dpwm_timebase.sv
module dpwm_timebase #(
  parameter int PRE_W = 8,
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PRE_W-1:0] act_pre,
  input  logic [PER_W-1:0] act_per,
  output logic [PER_W-1:0] cnt,
  output logic             wrap
);
  logic [PRE_W-1:0] pre_cnt;
  logic             tick;
  logic [PER_W:0]   cnt_inc;

  assign tick    = run && (pre_cnt >= act_pre);
  assign cnt_inc = {1'b0, cnt} + {{PER_W{1'b0}}, 1'b1};
  assign wrap    = tick && (cnt_inc >= {1'b0, act_per});

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pre_cnt <= '0;
    end else if (tick) begin
      pre_cnt <= '0;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (wrap) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt_inc[PER_W-1:0];
    end
  end
endmodule

// File: rtl/dpwm_dither.sv
module dpwm_dither #(
  parameter int DUTY_W    = 12,
  parameter int FRAME_LEN = 10,
  localparam int REM_W    = $clog2(FRAME_LEN),
  localparam int IDX_W    = $clog2(FRAME_LEN),
  localparam int SUM_W    = $clog2(2 * FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              wrap,
  input  logic [DUTY_W-1:0] nx_coarse,
  input  logic [REM_W-1:0]  nx_rem,
  output logic [DUTY_W-1:0] cmp,
  output logic              frame_wrap
);
  logic [IDX_W-1:0] idx;
  logic [SUM_W-1:0] acc;
  logic [SUM_W-1:0] base;
  logic [SUM_W-1:0] sum;
  logic             up;

  assign frame_wrap = wrap && (idx == IDX_W'(FRAME_LEN - 1));

  // Error diffusion: a fresh frame starts with an empty accumulator
  assign base = load ? '0 : acc;
  assign sum  = base + SUM_W'(nx_rem);
  assign up   = (sum >= SUM_W'(FRAME_LEN));

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
      acc <= '0;
      cmp <= '0;
    end else if (load || wrap) begin
      idx <= load ? '0 : idx + 1'b1;
      acc <= up ? sum - SUM_W'(FRAME_LEN) : sum;
      cmp <= nx_coarse + DUTY_W'(up);
    end
  end
endmodule

// File: rtl/dpwm_top.sv
module dpwm_top
  import dpwm_pkg::*;
#(
  parameter int PRE_W     = 8,
  parameter int PER_W     = 8,
  parameter int FRAME_LEN = DEF_FRAME_LEN,
  localparam int REM_W    = $clog2(FRAME_LEN),
  localparam int DUTY_W   = PER_W + REM_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PRE_W-1:0]  prescale_i,
  input  logic [PER_W-1:0]  period_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              pwm_o,
  output logic              period_stb_o,
  output logic              frame_stb_o
);
  phase_t            phase;
  logic              run;
  logic              load;
  logic              wrap;
  logic              frame_wrap;
  logic [PRE_W-1:0]  act_pre;
  logic [PER_W-1:0]  act_per;
  logic [DUTY_W-1:0] act_coarse;
  logic [REM_W-1:0]  act_rem;
  logic [DUTY_W-1:0] nx_coarse;
  logic [REM_W-1:0]  nx_rem;
  logic [PER_W-1:0]  cnt;
  logic [DUTY_W-1:0] cmp;

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_LOAD;
    else     phase <= PH_RUN;
  end

  assign run  = (phase == PH_RUN);
  assign load = !run || frame_wrap;

  dpwm_shadow #(
    .PRE_W(PRE_W), .PER_W(PER_W), .DUTY_W(DUTY_W), .FRAME_LEN(FRAME_LEN)
  ) u_shadow (
    .clk(clk), .rst(rst), .load(load),
    .pre_i(prescale_i), .per_i(period_i), .duty_i(duty_i),
    .act_pre(act_pre), .act_per(act_per),
    .act_coarse(act_coarse), .act_rem(act_rem),
    .nx_coarse(nx_coarse), .nx_rem(nx_rem)
  );

  dpwm_timebase #(
    .PRE_W(PRE_W), .PER_W(PER_W)
  ) u_timebase (
    .clk(clk), .rst(rst), .run(run),
    .act_pre(act_pre), .act_per(act_per),
    .cnt(cnt), .wrap(wrap)
  );

  dpwm_dither #(
    .DUTY_W(DUTY_W), .FRAME_LEN(FRAME_LEN)
  ) u_dither (
    .clk(clk), .rst(rst), .load(load), .wrap(wrap),
    .nx_coarse(nx_coarse), .nx_rem(nx_rem),
    .cmp(cmp), .frame_wrap(frame_wrap)
  );

  // Registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_o        <= 1'b0;
      period_stb_o <= 1'b0;
      frame_stb_o  <= 1'b0;
    end else begin
      pwm_o        <= run && (DUTY_W'(cnt) < cmp);
      period_stb_o <= load || wrap;
      frame_stb_o  <= load;
    end
  end
endmodule

// File: rtl/dpwm_chk.sv
module dpwm_chk #(
  parameter int PER_W  = 8,
  parameter int DUTY_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              per_stb,
  input logic              frame_stb,
  input logic              pwm,
  input logic [PER_W-1:0]  cnt,
  input logic [PER_W-1:0]  act_per,
  input logic [DUTY_W-1:0] act_coarse,
  input logic [DUTY_W-1:0] cmp
);
  // R1
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    (act_per != '0) |-> (cnt < act_per));

  // R2
  frame_on_period_chk: assert property (@(posedge clk) disable iff (rst)
    frame_stb |-> per_stb);

  // R4
  level_adjacent_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp == act_coarse) || (cmp == act_coarse + 1'b1));

  // R5
  zero_low_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp == '0) |=> !pwm);

  // R6
  full_high_chk: assert property (@(posedge clk) disable iff (rst)
    ((act_per != '0) && (DUTY_W'(act_per) <= cmp)) |=> pwm);

  // R7
  hold_settings_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_stb |-> ($stable(act_per) && $stable(act_coarse)));
endmodule

bind dpwm_top dpwm_chk #(.PER_W(PER_W), .DUTY_W(DUTY_W)) u_chk (
  .clk(clk), .rst(rst), .per_stb(period_stb_o), .frame_stb(frame_stb_o),
  .pwm(pwm_o), .cnt(cnt), .act_per(act_per), .act_coarse(act_coarse),
  .cmp(cmp)
);

// File: tb/dpwm_top_tb.sv
module dpwm_top_tb;
  localparam int NV = 8;
  // {prescale, period, duty, frame high cycles, frame length}
  localparam int VEC [NV][5] = '{
    '{0,  20,  84,  84,  200},
    '{1,  20,  84, 168,  400},
    '{0, 100, 423, 423, 1000},
    '{0,  20,   0,   0,  200},
    '{0,  20, 200, 200,  200},
    '{0,  20, 205, 200,  200},
    '{2,  10,  37, 111,  300},
    '{0,  16, 250, 160,  160}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  prescale_i = '0;
  logic [7:0]  period_i = '0;
  logic [11:0] duty_i = '0;
  logic        pwm_o, period_stb_o, frame_stb_o;

  int nchk = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  dpwm_top u_dut (
    .clk(clk), .rst(rst), .prescale_i(prescale_i), .period_i(period_i),
    .duty_i(duty_i), .pwm_o(pwm_o), .period_stb_o(period_stb_o),
    .frame_stb_o(frame_stb_o)
  );

  // Output monitor, sampled on the falling edge
  int hi_f = 0, len_f = 0, hi_p = 0, len_p = 0, sidx = 0;
  int pslot [16];
  int fslot [16];
  int last_fhi = 0, last_flen = 0, last_plen = 0, last_nslots = 0;
  int nframes = 0, misalign = 0;

  always @(negedge clk) begin
    if (rst) begin
      hi_f = 0; len_f = 0; hi_p = 0; len_p = 0; sidx = 0;
    end else begin
      hi_f += int'(pwm_o); len_f++;
      hi_p += int'(pwm_o); len_p++;
      if (frame_stb_o && !period_stb_o) misalign++;
      if (period_stb_o) begin
        if (sidx < 16) pslot[sidx] = hi_p;
        last_plen = len_p;
        hi_p = 0; len_p = 0;
        if (frame_stb_o) begin
          for (int k = 0; k < 16; k++) fslot[k] = pslot[k];
          last_fhi = hi_f; last_flen = len_f; last_nslots = sidx + 1;
          hi_f = 0; len_f = 0; sidx = 0;
          nframes++;
        end else begin
          sidx++;
        end
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_frames(input int n);
    int target = nframes + n;
    while (nframes < target) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic set_in(input int p, input int n, input int d);
    prescale_i = 8'(p);
    period_i   = 8'(n);
    duty_i     = 12'(d);
  endtask

  initial begin
    #(4 * 150000);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", nframes, -1);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    // R8: outputs quiet during reset
    set_in(0, 20, 84);
    repeat (4) @(negedge clk);
    check("R8 pwm in reset", int'(pwm_o), 0);
    check("R8 period strobe in reset", int'(period_stb_o), 0);
    check("R8 frame strobe in reset", int'(frame_stb_o), 0);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R8 first frame strobe", int'(frame_stb_o), 1);
    check("R8 first period strobe", int'(period_stb_o), 1);

    for (int v = 0; v < NV; v++) begin
      int d, c, f, n;
      set_in(VEC[v][0], VEC[v][1], VEC[v][2]);
      wait_frames(3);
      d = VEC[v][0] + 1;
      n = VEC[v][1];
      c = VEC[v][2] / 10;
      f = VEC[v][2] % 10;
      check($sformatf("R3 frame high v%0d", v), last_fhi, VEC[v][3]);
      check($sformatf("R1 frame length v%0d", v), last_flen, VEC[v][4]);
      check($sformatf("R1 period length v%0d", v), last_plen, n * d);
      check($sformatf("R2 periods per frame v%0d", v), last_nslots, 10);
      for (int k = 0; k < 10; k++) begin
        int lvl;
        lvl = c + ((((k + 1) * f) / 10 > (k * f) / 10) ? 1 : 0);
        if (lvl > n) lvl = n;
        // R5 for duty 0, R6 for levels at or above the period
        check($sformatf("R4 slot %0d v%0d", k, v), fslot[k], lvl * d);
      end
    end

    // R7: change inputs in the middle of a frame
    wait_frames(1);
    repeat (20) @(posedge clk);
    #1 set_in(0, 20, 84);
    wait_frames(1);
    check("R7 running frame length kept", last_flen, 160);
    check("R7 running frame high kept", last_fhi, 160);
    wait_frames(2);
    check("R7 new frame length", last_flen, 200);
    check("R7 new frame high", last_fhi, 84);

    // R2: the frame strobe never appeared without the period strobe
    check("R2 strobe alignment", misalign, 0);

    // R8: reset again while running
    @(posedge clk); #1 rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 pwm after re-reset", int'(pwm_o), 0);
    check("R8 period strobe after re-reset", int'(period_stb_o), 0);
    check("R8 frame strobe after re-reset", int'(frame_stb_o), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule